// File: doc/BRIEF.md
# Self-Starting Three-State Up/Down Counter

This block is a 2-bit synchronous counter whose legal values are 1, 2 and 3. A direction input chooses the way it steps. Counting up runs 1, 2, 3 and then wraps back to 1. Counting down runs 3, 2, 1 and then wraps back to 3. The output is the state register itself, with no decoding after it.

Code 0 is not part of either cycle. If the register ever holds 0, it moves to 3 on the next clock whatever the direction input is, so the counter cannot lock up in that code. The next state comes from one toggle enable per bit: a control module computes the two enables from the state and the direction, and a datapath register XORs them into its bits.

A parameter sets the value loaded on reset. By default reset loads 1. Setting the parameter to 0 lets the recovery path be tried from the ports.

Top module: `trio_counter`

## Requirements
- R1: With `dirUp` = 1, `count` steps 1 → 2 → 3 → 1 on successive rising clock edges and keeps repeating.
- R2: With `dirUp` = 0, `count` steps 3 → 2 → 1 → 3 on successive rising clock edges and keeps repeating.
- R3: `count` is the state register with no decoding. Each step of R1 and R2 appears on `count` after exactly one clock edge.
- R4: When the state is 0, the next rising edge loads 3. This holds for `dirUp` = 0 and for `dirUp` = 1.
- R5: While `rst` is high at a rising edge, the state loads `RESET_STATE`, which defaults to 1. Reset is synchronous and active high.
- R6: From any legal state (1, 2 or 3), the next state is never 0, in either direction.
- R7: If `dirUp` changes partway through a sequence, the step at the next edge follows the new direction, starting from the current state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| dirUp | input | 1 | 1 counts up, 0 counts down |
| count | output | 2 | Current state value |

## Verification
The main instance runs several steady up cycles and several steady down cycles, each crossing its wrap point more than once. These runs separate the correct wrap targets (3 to 1 going up, 1 to 3 going down) from a wrap that passes through 0. Direction flips made at each legal state show that the step follows the new direction from the current value and not from a stale one. A second instance with reset value 0 is released once with each direction input. This separates the fixed recovery to 3 from a recovery that depends on the direction.

// File: rtl/trio_pkg.sv
package trio_pkg;
  localparam int STATE_W = 2;
  typedef logic [STATE_W-1:0] state_t;

  // Per-bit toggle strobes from control to datapath.
  typedef struct packed {
    logic flipHi;
    logic flipLo;
  } toggle_t;
endpackage

// File: rtl/trio_ctrl.sv
module trio_ctrl
  import trio_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    dirUp,
  input  state_t  stateQ,
  output toggle_t flips
);

  always_comb begin
    // Upper bit holds only on 2->3 (up) and 3->2 (down).
    flips.flipHi = ~stateQ[1] | (dirUp ~^ stateQ[0]);
    // Lower bit holds only on 3->1 (up) and 1->3 (down).
    flips.flipLo = ~stateQ[0] | (stateQ[1] ^ dirUp);
  end

  // Sequence checks, on the state the datapath registers.
  p_up_one_r1: assert property (@(posedge clk) disable iff (rst)
    (dirUp && stateQ == 2'd1) |=> stateQ == 2'd2);
  p_up_two_r1: assert property (@(posedge clk) disable iff (rst)
    (dirUp && stateQ == 2'd2) |=> stateQ == 2'd3);
  p_up_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (dirUp && stateQ == 2'd3) |=> stateQ == 2'd1);
  p_dn_three_r2: assert property (@(posedge clk) disable iff (rst)
    (!dirUp && stateQ == 2'd3) |=> stateQ == 2'd2);
  p_dn_two_r2: assert property (@(posedge clk) disable iff (rst)
    (!dirUp && stateQ == 2'd2) |=> stateQ == 2'd1);
  p_dn_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (!dirUp && stateQ == 2'd1) |=> stateQ == 2'd3);
  p_recover_r4: assert property (@(posedge clk) disable iff (rst)
    (stateQ == 2'd0) |=> stateQ == 2'd3);
  p_no_trap_r6: assert property (@(posedge clk) disable iff (rst)
    (stateQ != 2'd0) |=> stateQ != 2'd0);

endmodule

// File: rtl/trio_dp.sv
module trio_dp
  import trio_pkg::*;
#(
  parameter state_t RESET_STATE = 2'd1
) (
  input  logic    clk,
  input  logic    rst,
  input  toggle_t flips,
  output state_t  stateQ
);

  state_t flipVec;
  assign flipVec = {flips.flipHi, flips.flipLo};

  for (genvar b = 0; b < STATE_W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) stateQ[b] <= RESET_STATE[b];
      else     stateQ[b] <= stateQ[b] ^ flipVec[b];
    end
  end

  p_reset_load_r5: assert property (@(posedge clk)
    rst |=> stateQ == RESET_STATE);

endmodule

// File: rtl/trio_counter.sv
module trio_counter
  import trio_pkg::*;
#(
  parameter state_t RESET_STATE = 2'd1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       dirUp,
  output logic [1:0] count
);

  toggle_t flips;
  state_t  stateQ;

  trio_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .dirUp  (dirUp),
    .stateQ (stateQ),
    .flips  (flips)
  );

  trio_dp #(.RESET_STATE(RESET_STATE)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .flips  (flips),
    .stateQ (stateQ)
  );

  assign count = stateQ;

endmodule

// File: tb/trio_counter_bench.sv
`timescale 1ns/1ps
module trio_counter_bench;
  logic clk = 1'b0;
  logic rst = 1'b1, dirUp = 1'b1;
  logic rstZ = 1'b1, dirZ = 1'b0;
  logic [1:0] count, countZ;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  trio_counter u_trio_counter (.clk(clk), .rst(rst), .dirUp(dirUp), .count(count));
  trio_counter #(.RESET_STATE(2'd0)) u_trio_counter_zero (
    .clk(clk), .rst(rstZ), .dirUp(dirZ), .count(countZ));

  function automatic logic [1:0] expNext(logic [1:0] s, logic up);
    if (s == 2'd0) return 2'd3;
    if (up) return (s == 2'd3) ? 2'd1 : s + 2'd1;
    return (s == 2'd1) ? 2'd3 : s - 2'd1;
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: count=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock with the given direction; sampled at the following negedge.
  task automatic step(string req, logic up);
    logic [1:0] e;
    e = expNext(count, up);
    dirUp = up;
    @(negedge clk);
    check(req, count, e);
  endtask

  task automatic testReset;
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R5", count, 2'd1);
    rst = 1'b0;
  endtask

  task automatic testUp;
    for (int i = 0; i < 7; i++) step("R1", 1'b1);
  endtask

  task automatic testDown;
    for (int i = 0; i < 7; i++) step("R2", 1'b0);
  endtask

  task automatic testSwitch;
    // Flip direction at each legal state.
    step("R7", 1'b1); step("R7", 1'b0); step("R7", 1'b1);
    step("R7", 1'b1); step("R7", 1'b0); step("R7", 1'b0);
    step("R7", 1'b1); step("R7", 1'b0); step("R3", 1'b0);
  endtask

  task automatic testRecover(logic up);
    rstZ = 1'b1; dirZ = up;
    @(negedge clk); @(negedge clk);
    check("R5", countZ, 2'd0);
    rstZ = 1'b0;
    @(negedge clk);
    check("R4", countZ, 2'd3);
    @(negedge clk);
    check("R6", countZ, up ? 2'd1 : 2'd2);
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testUp();
    testDown();
    testSwitch();
    testReset();
    step("R3", 1'b1);
    testRecover(1'b0);
    testRecover(1'b1);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: count=%0d expected=done", count);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule